// File: doc/BRIEF.md
# System Exception Control and State Registers

This block keeps the pending state of the fixed system exceptions (NMI, PendSV, SysTick, SVC, memory-management fault, bus fault, usage fault and debug monitor). It also holds the software-visible control words that go with them. Software reaches it through a simple 32-bit register port addressed by word offset. Hardware event sources raise and acknowledge pending state through per-exception set and clear strobes. The surrounding exception logic supplies the current active vector, the highest pending vector and the external interrupt pending lines, and this block reports them in its state word.

Along with the pending state, the block stores the handler priority bytes, the fault-handler enables, a vector table base and a key-protected reset/control register. Its outputs are a reset-request pulse, a clear-active pulse and a priority grouping field. Priority arbitration is not done here; the priority bytes are only stored and exported.

Top module: `sysexc_regs`

## Requirements
- R1: A write to the state word (offset 1) with bit 31 set makes NMI pending (pend_o bit 0) from the next cycle.
- R2: In a state-word write, bit 28 sets PendSV pending (pend_o bit 6) and bit 27 clears it; with both bits set, PendSV ends pending.
- R3: In a state-word write, bit 26 sets SysTick pending (pend_o bit 7) and bit 25 clears it; with both bits set, SysTick ends pending.
- R4: hw_set_pend_i[i] makes exception i pending on the next cycle and hw_clr_pend_i[i] clears it. When both strobes (or a set from either source and a clear) arrive together, the set wins. Exception indices: 0 NMI, 1 MemManage, 2 BusFault, 3 UsageFault, 4 SVC, 5 debug, 6 PendSV, 7 SysTick.
- R5: A read returns its data on rdata_o in the cycle after the request, and rdata_o is zero after a cycle with no read. In the state word, bits 8:0 hold act_vec_i when act_valid_i is high and zero otherwise. Bit 11 is high when act_valid_i is low or act_only_i is high.
- R6: In the state word, bits 20:12 hold pend_vec_i when pend_valid_i is high (else zero). Bit 22 is the OR of ext_pend_i. Bits 26, 28 and 31 are SysTick, PendSV and NMI pending.
- R7: The handler status word (offset 7) shows the active flags in bits 0, 1, 3, 7, 8, 10, 11 for MemManage, BusFault, UsageFault, SVC, debug, PendSV and SysTick. It shows the pending flags in bits 12 to 15 for UsageFault, MemManage, BusFault and SVC.
- R8: Handler status bits 16, 17 and 18 are writable enables for MemManage, BusFault and UsageFault, driven on fault_en_o[2:0]. All other written bits of that word are ignored.
- R9: A write to the reset/control word (offset 3) takes effect only when bits 31:16 equal 0x05FA. An accepted write stores bits 10:8 as prigroup_o, pulses rst_req_o for one cycle if bit 2 is set, and pulses clr_act_o for one cycle if bit 1 is set. A read returns 0xFA05 in bits 31:16 and the stored grouping in bits 10:8.
- R10: The vector base word (offset 2) stores the written value with bits 6:0 forced to zero, on vtor_o and on read.
- R11: Offsets 4, 5 and 6 each pack four 8-bit handler priorities for handlers 4-7, 8-11 and 12-15. The lowest handler sits in the least significant byte. prio_o byte i holds handler 4+i.
- R12: The type word (offset 0) reads N_EXT/32 - 1, the number of 32-line external interrupt groups minus one.
- R13: An access to an offset above 7 reads zero, raises err_o for exactly the following cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | AW | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | Unimplemented-offset response, one cycle after the request |
| act_valid_i | input | 1 | An exception is active |
| act_vec_i | input | VW | Active exception number |
| act_only_i | input | 1 | Active exception is the only one nested |
| pend_valid_i | input | 1 | Some vector is pending |
| pend_vec_i | input | VW | Highest pending vector number |
| ext_pend_i | input | N_EXT | External interrupt pending lines |
| active_i | input | 8 | Per-exception active flags |
| hw_set_pend_i | input | 8 | Hardware set-pending strobes |
| hw_clr_pend_i | input | 8 | Acknowledge / clear-pending strobes |
| pend_o | output | 8 | Per-exception pending state |
| fault_en_o | output | 3 | UsageFault, BusFault, MemManage enables (bits 2..0) |
| prio_o | output | NPW*32 | Handler priority bytes, handler 4 in the low byte |
| vtor_o | output | 32 | Vector table base |
| prigroup_o | output | 3 | Priority grouping field |
| rst_req_o | output | 1 | One-cycle system reset request |
| clr_act_o | output | 1 | One-cycle clear-active request |

## Verification
A write or a hardware strobe updates pend_o, fault_en_o, vtor_o, prio_o and prigroup_o at the first rising edge that samples it. The reset and clear-active pulses appear at that same edge and are gone one edge later. A read, and the error flag of a bad offset, are due in the cycle after the request, registered at the sampling edge. The bench drives each request on a falling edge and samples every result on the next falling edge, half a period after the edge that produced it. It then waits one more cycle to confirm that pulses and err_o have dropped.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
  localparam int NEXC = 8;
  localparam int I_NMI = 0;
  localparam int I_MEM = 1;
  localparam int I_BUS = 2;
  localparam int I_USG = 3;
  localparam int I_SVC = 4;
  localparam int I_DBG = 5;
  localparam int I_PSV = 6;
  localparam int I_STK = 7;

  localparam logic [15:0] WR_KEY = 16'h05FA;
  localparam logic [15:0] RD_KEY = 16'hFA05;
endpackage

// File: rtl/sysexc_pend.sv
module sysexc_pend #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[i] <= 1'b0;
      else if (set_i[i]) pend_o[i] <= 1'b1;  // set wins
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sysexc_prio.sv
module sysexc_prio #(
  parameter int NW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NW-1:0]    we_i,
  input  logic [31:0]      wdata_i,
  output logic [NW*32-1:0] prio_o
);
  for (genvar k = 0; k < NW; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     prio_o[k*32 +: 32] <= '0;
      else if (we_i[k]) prio_o[k*32 +: 32] <= wdata_i;
    end
  end
endmodule

// File: rtl/sysexc_rstc.sv
module sysexc_rstc
  import sysexc_pkg::*;
#(
  parameter int GW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [31:0]   wdata_i,
  output logic [GW-1:0] group_o,
  output logic          rst_req_o,
  output logic          clr_act_o,
  output logic [31:0]   rd_o
);
  logic acc;
  assign acc = wr_i && (wdata_i[31:16] == WR_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      group_o   <= '0;
      rst_req_o <= 1'b0;
      clr_act_o <= 1'b0;
    end else begin
      rst_req_o <= acc && wdata_i[2];
      clr_act_o <= acc && wdata_i[1];
      if (acc) group_o <= wdata_i[8 +: GW];
    end
  end

  always_comb begin
    rd_o = '0;
    rd_o[31:16] = RD_KEY;
    rd_o[8 +: GW] = group_o;
  end

  logic unused_wd;
  assign unused_wd = ^{wdata_i[15:8+GW], wdata_i[7:3], wdata_i[0]};
endmodule

// File: rtl/sysexc_regs.sv
module sysexc_regs
  import sysexc_pkg::*;
#(
  parameter int N_EXT = 64,
  parameter int AW    = 4,
  parameter int VW    = 9,
  parameter int NPW   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             err_o,
  input  logic             act_valid_i,
  input  logic [VW-1:0]    act_vec_i,
  input  logic             act_only_i,
  input  logic             pend_valid_i,
  input  logic [VW-1:0]    pend_vec_i,
  input  logic [N_EXT-1:0] ext_pend_i,
  input  logic [NEXC-1:0]  active_i,
  input  logic [NEXC-1:0]  hw_set_pend_i,
  input  logic [NEXC-1:0]  hw_clr_pend_i,
  output logic [NEXC-1:0]  pend_o,
  output logic [2:0]       fault_en_o,
  output logic [NPW*32-1:0] prio_o,
  output logic [31:0]      vtor_o,
  output logic [2:0]       prigroup_o,
  output logic             rst_req_o,
  output logic             clr_act_o
);
  localparam int N_GRP     = N_EXT / 32;
  localparam int OFF_TYPE  = 0;
  localparam int OFF_CTRL  = 1;
  localparam int OFF_VTOR  = 2;
  localparam int OFF_RSTC  = 3;
  localparam int OFF_PRIO  = 4;
  localparam int OFF_HSTAT = OFF_PRIO + NPW;

  logic wr, rd;
  logic hit;
  logic wr_ctrl;
  logic [NEXC-1:0] sw_set, sw_clr;
  logic [NPW-1:0]  prio_we;
  logic [31:0]     rstc_rd, rd_val;

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign hit     = int'(addr_i) <= OFF_HSTAT;
  assign wr_ctrl = wr && (addr_i == AW'(OFF_CTRL));

  always_comb begin
    sw_set = '0;
    sw_clr = '0;
    sw_set[I_NMI] = wr_ctrl && wdata_i[31];
    sw_set[I_PSV] = wr_ctrl && wdata_i[28];
    sw_clr[I_PSV] = wr_ctrl && wdata_i[27];
    sw_set[I_STK] = wr_ctrl && wdata_i[26];
    sw_clr[I_STK] = wr_ctrl && wdata_i[25];
  end

  sysexc_pend #(.N(NEXC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hw_set_pend_i | sw_set),
    .clr_i  (hw_clr_pend_i | sw_clr),
    .pend_o (pend_o)
  );

  for (genvar k = 0; k < NPW; k++) begin : g_pwe
    assign prio_we[k] = wr && (addr_i == AW'(OFF_PRIO + k));
  end

  sysexc_prio #(.NW(NPW)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (prio_we),
    .wdata_i (wdata_i),
    .prio_o  (prio_o)
  );

  sysexc_rstc #(.GW(3)) u_rstc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr && (addr_i == AW'(OFF_RSTC))),
    .wdata_i   (wdata_i),
    .group_o   (prigroup_o),
    .rst_req_o (rst_req_o),
    .clr_act_o (clr_act_o),
    .rd_o      (rstc_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vtor_o     <= '0;
      fault_en_o <= '0;
    end else begin
      if (wr && addr_i == AW'(OFF_VTOR))  vtor_o     <= {wdata_i[31:7], 7'b0};
      if (wr && addr_i == AW'(OFF_HSTAT)) fault_en_o <= wdata_i[18:16];
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == AW'(OFF_TYPE)) begin
      rd_val = 32'(N_GRP - 1);
    end else if (addr_i == AW'(OFF_CTRL)) begin
      rd_val[VW-1:0]  = act_valid_i ? act_vec_i : '0;
      rd_val[11]      = !act_valid_i || act_only_i;
      rd_val[12 +: VW] = pend_valid_i ? pend_vec_i : '0;
      rd_val[22]      = |ext_pend_i;
      rd_val[26]      = pend_o[I_STK];
      rd_val[28]      = pend_o[I_PSV];
      rd_val[31]      = pend_o[I_NMI];
    end else if (addr_i == AW'(OFF_VTOR)) begin
      rd_val = vtor_o;
    end else if (addr_i == AW'(OFF_RSTC)) begin
      rd_val = rstc_rd;
    end else if (addr_i == AW'(OFF_HSTAT)) begin
      rd_val[0]  = active_i[I_MEM];
      rd_val[1]  = active_i[I_BUS];
      rd_val[3]  = active_i[I_USG];
      rd_val[7]  = active_i[I_SVC];
      rd_val[8]  = active_i[I_DBG];
      rd_val[10] = active_i[I_PSV];
      rd_val[11] = active_i[I_STK];
      rd_val[12] = pend_o[I_USG];
      rd_val[13] = pend_o[I_MEM];
      rd_val[14] = pend_o[I_BUS];
      rd_val[15] = pend_o[I_SVC];
      rd_val[18:16] = fault_en_o;
    end else begin
      for (int k = 0; k < NPW; k++)
        if (addr_i == AW'(OFF_PRIO + k)) rd_val = prio_o[k*32 +: 32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= (rd && hit) ? rd_val : '0;
      err_o   <= req_i && !hit;
    end
  end

  logic unused_act;
  assign unused_act = active_i[I_NMI];
endmodule

// File: rtl/sysexc_regs_chk.sv
module sysexc_regs_chk
  import sysexc_pkg::*;
#(
  parameter int AW = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [31:0]     wdata_i,
  input logic            err_o,
  input logic [NEXC-1:0] hw_set_pend_i,
  input logic [NEXC-1:0] pend_o,
  input logic [2:0]      fault_en_o,
  input logic [31:0]     vtor_o,
  input logic            rst_req_o
);
  logic wctl;
  assign wctl = req_i && we_i && addr_i == AW'(1);

  AST_NMI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wctl && wdata_i[31] |=> pend_o[I_NMI]);  // R1
  AST_PSV_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wctl && wdata_i[28] |=> pend_o[I_PSV]);  // R2
  AST_STK_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wctl && wdata_i[26] |=> pend_o[I_STK]);  // R3
  AST_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_pend_i != '0 |=> (pend_o & $past(hw_set_pend_i)) == $past(hw_set_pend_i));  // R4
  AST_EN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == AW'(7)) |=> $stable(fault_en_o));  // R8
  AST_BAD_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == AW'(3) && wdata_i[31:16] != WR_KEY |=> !rst_req_o);  // R9
  AST_VTOR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtor_o[6:0] == 7'd0);  // R10
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i) && int'($past(addr_i)) > 7);  // R13
endmodule

bind sysexc_regs sysexc_regs_chk #(.AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .err_o         (err_o),
  .hw_set_pend_i (hw_set_pend_i),
  .pend_o        (pend_o),
  .fault_en_o    (fault_en_o),
  .vtor_o        (vtor_o),
  .rst_req_o     (rst_req_o)
);

// File: tb/sysexc_regs_tb.sv
module sysexc_regs_tb;
  localparam int N_EXT = 64;
  localparam int AW = 4;
  localparam int VW = 9;
  localparam int NPW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err;
  logic act_valid = 1'b0, act_only = 1'b0, pend_valid = 1'b0;
  logic [VW-1:0] act_vec = '0, pend_vec = '0;
  logic [N_EXT-1:0] ext_pend = '0;
  logic [7:0] active = '0, hw_set = '0, hw_clr = '0;
  logic [7:0] pend;
  logic [2:0] fault_en, prigroup;
  logic [NPW*32-1:0] prio;
  logic [31:0] vtor;
  logic rst_req, clr_act;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysexc_regs #(.N_EXT(N_EXT), .AW(AW), .VW(VW), .NPW(NPW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .act_valid_i(act_valid), .act_vec_i(act_vec), .act_only_i(act_only),
    .pend_valid_i(pend_valid), .pend_vec_i(pend_vec), .ext_pend_i(ext_pend),
    .active_i(active), .hw_set_pend_i(hw_set), .hw_clr_pend_i(hw_clr),
    .pend_o(pend), .fault_en_o(fault_en), .prio_o(prio), .vtor_o(vtor),
    .prigroup_o(prigroup), .rst_req_o(rst_req), .clr_act_o(clr_act)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic hw_pulse(input logic [7:0] s, input logic [7:0] c);
    @(negedge clk);
    hw_set = s; hw_clr = c;
    @(negedge clk);
    hw_set = '0; hw_clr = '0;
  endtask

  task automatic t_reset;
    chk("R4 reset pend", 32'(pend), 32'h0);
    chk("R8 reset enables", 32'(fault_en), 32'h0);
    chk("R10 reset vtor", vtor, 32'h0);
    chk("R11 reset prio", 32'(|prio), 32'h0);
    chk("R13 reset err", 32'(err), 32'h0);
    chk("R9 reset pulse", 32'({rst_req, clr_act}), 32'h0);
  endtask

  task automatic t_type;
    logic [31:0] d;
    rd_reg(0, d);
    chk("R12 type word", d, 32'(N_EXT / 32 - 1));
    @(negedge clk);
    chk("R5 rdata idle zero", rdata, 32'h0);
  endtask

  task automatic t_nmi;
    logic [31:0] d;
    wr_reg(1, 32'h8000_0000);
    chk("R1 nmi pending", 32'(pend[0]), 32'h1);
    rd_reg(1, d);
    chk("R6 nmi readback bit31", 32'(d[31]), 32'h1);
  endtask

  task automatic t_pendsv;
    wr_reg(1, 32'h1000_0000);
    chk("R2 pendsv set", 32'(pend[6]), 32'h1);
    wr_reg(1, 32'h0800_0000);
    chk("R2 pendsv clear", 32'(pend[6]), 32'h0);
    wr_reg(1, 32'h1800_0000);
    chk("R2 pendsv set wins", 32'(pend[6]), 32'h1);
  endtask

  task automatic t_systick;
    wr_reg(1, 32'h0400_0000);
    chk("R3 systick set", 32'(pend[7]), 32'h1);
    wr_reg(1, 32'h0200_0000);
    chk("R3 systick clear", 32'(pend[7]), 32'h0);
    wr_reg(1, 32'h0600_0000);
    chk("R3 systick set wins", 32'(pend[7]), 32'h1);
  endtask

  task automatic t_hw;
    hw_pulse(8'hFF, 8'h00);
    chk("R4 hw set all", 32'(pend), 32'hFF);
    hw_pulse(8'h04, 8'hFF);
    chk("R4 hw set beats clear", 32'(pend), 32'h04);
    hw_pulse(8'h00, 8'hFF);
    chk("R4 hw clear", 32'(pend), 32'h00);
  endtask

  task automatic t_ctrl_read;
    logic [31:0] d;
    act_valid = 1'b0; act_vec = 9'd11; pend_valid = 1'b0; pend_vec = 9'd37;
    rd_reg(1, d);
    chk("R5 idle active field and ret-to-base", d, 32'h0000_0800);
    act_valid = 1'b1; act_only = 1'b0; pend_valid = 1'b1;
    ext_pend = 64'h1 << 40;
    wr_reg(1, 32'h0400_0000);
    rd_reg(1, d);
    chk("R6 full state word", d, (32'd11) | (32'd37 << 12) | (32'h1 << 22) | (32'h1 << 26));
    act_only = 1'b1; ext_pend = '0;
    rd_reg(1, d);
    chk("R5 only-nested ret-to-base", d, 32'd11 | 32'h800 | (32'd37 << 12) | (32'h1 << 26));
    act_valid = 1'b0; act_only = 1'b0; pend_valid = 1'b0;
    hw_pulse(8'h00, 8'hFF);
  endtask

  task automatic t_hstat;
    logic [31:0] d;
    active = 8'hFF;
    hw_pulse(8'h1E, 8'h00);
    wr_reg(7, 32'hFFFF_FFFF);
    chk("R8 enables written", 32'(fault_en), 32'h7);
    rd_reg(7, d);
    chk("R7 handler status layout", d, 32'h0000_0D8B | 32'h0000_F000 | 32'h0007_0000);
    active = 8'h00;
    wr_reg(7, 32'h0002_FFFF);
    chk("R8 only bits 18:16 matter", 32'(fault_en), 32'h2);
    chk("R8 write leaves pending", 32'(pend), 32'h1E);
    hw_pulse(8'h00, 8'hFF);
  endtask

  task automatic t_rstc;
    logic [31:0] d;
    wr_reg(3, 32'h1234_0506);
    chk("R9 bad key no reset", 32'(rst_req), 32'h0);
    chk("R9 bad key no group", 32'(prigroup), 32'h0);
    wr_reg(3, 32'h05FA_0506);
    chk("R9 reset pulse", 32'({rst_req, clr_act}), 32'h3);
    chk("R9 group stored", 32'(prigroup), 32'h5);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'({rst_req, clr_act}), 32'h0);
    rd_reg(3, d);
    chk("R9 readback", d, 32'hFA05_0500);
  endtask

  task automatic t_vtor;
    logic [31:0] d;
    wr_reg(2, 32'h2000_01FF);
    chk("R10 vtor aligned", vtor, 32'h2000_0180);
    rd_reg(2, d);
    chk("R10 vtor readback", d, 32'h2000_0180);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr_reg(4, 32'h4433_2211);
    wr_reg(5, 32'h8877_6655);
    wr_reg(6, 32'hCCBB_AA99);
    chk("R11 handler 4 low byte", 32'(prio[7:0]), 32'h11);
    chk("R11 handler 9", 32'(prio[47:40]), 32'h66);
    chk("R11 handler 15 top byte", 32'(prio[95:88]), 32'hCC);
    rd_reg(5, d);
    chk("R11 word readback", d, 32'h8877_6655);
  endtask

  task automatic t_bad;
    logic [31:0] d;
    rd_reg(9, d);
    chk("R13 bad read data", d, 32'h0);
    chk("R13 bad read err", 32'(err), 32'h1);
    @(negedge clk);
    chk("R13 err one cycle", 32'(err), 32'h0);
    wr_reg(12, 32'hFFFF_FFFF);
    chk("R13 bad write err", 32'(err), 32'h1);
    chk("R13 bad write no vtor", vtor, 32'h2000_0180);
    chk("R13 bad write no enables", 32'(fault_en), 32'h2);
    chk("R13 bad write no pend", 32'(pend), 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_type();
    t_nmi();
    t_pendsv();
    t_systick();
    t_hw();
    t_ctrl_read();
    t_hstat();
    t_rstc();
    t_vtor();
    t_prio();
    t_bad();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule